// File: doc/BRIEF.md
# Multi-Channel I/Q Sample Output Port

This block sits at the end of a four-channel receive path. Each channel delivers complex samples as a 16-bit in-phase word, a 16-bit quadrature word and a one-cycle valid strobe. The port keeps one unsent sample per channel and advertises waiting data with a request line. Each time the consumer's acknowledge meets an active request at a clock edge, the port puts the most urgent channel's sample on a shared 16-bit bus.

Two bus formats exist, selected by `fmt_pack`. The split format (`fmt_pack = 0`) sends the full I word and then the full Q word on two consecutive cycles. The packed format (`fmt_pack = 1`) sends the top byte of I and the top byte of Q together in one cycle. A flag output marks I-bearing cycles, and a 2-bit tag names the source channel. When `cfg_alt` is high the port leaves channel mode: it stops starting transfers but keeps capturing samples.

Top module: `iq_outport`

## Requirements
- R1: During and right after synchronous reset, `req_o`, `iq_o`, `ch_o` and `data_o` are all zero and no sample is pending.
- R2: With `cfg_alt = 0`, `req_o` is high in the cycle after an edge that leaves at least one channel with an unsent sample, and low once none remain.
- R3: A transfer begins at a rising edge where `req_o`, `ack_i` and idle coincide with `cfg_alt = 0`. In split format (`fmt_pack = 0`), `data_o` carries the full I word with `iq_o = 1` after that edge, and the full Q word with `iq_o = 0` after the next edge.
- R4: In packed format (`fmt_pack = 1`), a transfer is a single cycle with `data_o[15:8]` = I[15:8], `data_o[7:0]` = Q[15:8] and `iq_o = 1`.
- R5: In packed format, samples sent on consecutive cycles keep `iq_o` high without a gap. `iq_o` falls in the first cycle that carries no new sample.
- R6: `ch_o` holds the binary index (0 to 3) of the channel whose word is on `data_o`, and it stays unchanged across both halves of a split-format pair.
- R7: A channel holds at most one unsent sample. A newer strobe on a channel replaces that channel's unsent sample and leaves every other channel's sample alone.
- R8: When several channels are waiting, channel 0 is served first, then 1, 2 and 3.
- R9: If `ack_i` falls during a split-format pair, the Q word is still sent. After that, no transfer starts, `data_o` keeps its last value and `iq_o` stays low until `ack_i` is high again.
- R10: While `cfg_alt = 1`, no transfer starts, `iq_o` is low and `req_o` is low. Samples that arrive meanwhile are kept and are sent after `cfg_alt` returns to 0.
- R11: A sample that arrives on a channel at the edge its previous sample starts (or, in split format, at the Q edge) stays pending and is sent later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | 4x16 | In-phase sample per channel |
| smp_q | input | 4x16 | Quadrature sample per channel |
| smp_vld | input | 4 | Per-channel sample strobe |
| fmt_pack | input | 1 | 0 = split I then Q, 1 = packed 8/8 |
| cfg_alt | input | 1 | 0 = channel mode, 1 = output suspended |
| ack_i | input | 1 | Consumer acknowledge |
| req_o | output | 1 | Data waiting |
| data_o | output | 16 | Output data bus |
| iq_o | output | 1 | High in cycles that carry I data |
| ch_o | output | 2 | Source channel of the word on the bus |

## Verification
The embedded properties watch the local rules on every cycle. A Q cycle always has the flag low and the channel tag unchanged. The bus holds still while idle. A strobe always leaves its channel pending. The arbiter never passes over a higher-priority waiting channel. Request never rises without pending data, and the suspend input silences the flag. End-to-end facts need the bench's scenarios, run against a cycle model built from the requirements. These include the word sequence across channels, overwrite and renewal of pending samples, the packed byte layout, the flag staying high across packed bursts, and resumption after acknowledge gaps or suspension.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

  typedef enum logic {
    TX_IDLE   = 1'b0,
    TX_SECOND = 1'b1
  } tx_state_t;

  function automatic int id_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/iqp_hold.sv
module iqp_hold #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          consume,
  input  logic [DW-1:0] din_i,
  input  logic [DW-1:0] din_q,
  output logic          pend_o,
  output logic [DW-1:0] hold_i_o,
  output logic [DW-1:0] hold_q_o
);

  // A fresh load wins over a consume at the same edge.
  always_ff @(posedge clk) begin
    if (rst)          pend_o <= 1'b0;
    else if (load)    pend_o <= 1'b1;
    else if (consume) pend_o <= 1'b0;
  end

  // Data storage is left without reset so it maps onto plain registers or RAM.
  always_ff @(posedge clk) begin
    if (load) begin
      hold_i_o <= din_i;
      hold_q_o <= din_q;
    end
  end

  // R7: a strobe always leaves the channel pending with the newest sample.
  p_load_keeps_newest_r7: assert property (@(posedge clk) disable iff (rst)
    load |=> (pend_o && hold_i_o == $past(din_i) && hold_q_o == $past(din_q)));

endmodule

// File: rtl/iqp_arb.sv
module iqp_arb #(
  parameter int NCH = 4,
  parameter int CW  = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pend_i,
  output logic [CW-1:0]  idx_o
);

  logic [NCH-1:0] lower_mask;

  // Scan from the lowest priority upward so the lowest index wins.
  always_comb begin
    idx_o = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      if (pend_i[k]) idx_o = CW'(k);
    end
  end

  always_comb begin
    lower_mask = '0;
    for (int k = 0; k < NCH; k++) begin
      if (CW'(k) < idx_o) lower_mask[k] = 1'b1;
    end
  end

  // R8: the granted channel is pending and no higher-priority one is waiting.
  p_grant_highest_r8: assert property (@(posedge clk) disable iff (rst)
    (|pend_i) |-> (pend_i[idx_o] && ((pend_i & lower_mask) == '0)));

endmodule

// File: rtl/iqp_tx.sv
module iqp_tx
  import iqp_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int CW  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_i,
  input  logic                    ack_i,
  input  logic                    alt_i,
  input  logic                    fmt_i,
  input  logic [NCH-1:0]          vld_i,
  input  logic [CW-1:0]           sel_i,
  input  logic [NCH-1:0][DW-1:0]  hold_i,
  input  logic [NCH-1:0][DW-1:0]  hold_q,
  output logic [NCH-1:0]          consume_o,
  output logic [DW-1:0]           data_o,
  output logic                    iq_o,
  output logic [CW-1:0]           ch_o
);

  localparam int HB = DW / 2;

  tx_state_t     st_q;
  logic [DW-1:0] stage_q;
  logic          renew_q;
  logic          start;
  logic [DW-1:0] packed_word;

  assign start = req_i && ack_i && !alt_i && (st_q == TX_IDLE);

  always_comb begin
    packed_word = '0;
    packed_word[DW-1 -: HB]    = hold_i[sel_i][DW-1 -: HB];
    packed_word[DW-HB-1 -: HB] = hold_q[sel_i][DW-1 -: HB];
  end

  // Release the channel on its last word; a same-edge load in the hold wins.
  always_comb begin
    consume_o = '0;
    if (st_q == TX_SECOND) begin
      if (!renew_q) consume_o[ch_o] = 1'b1;
    end else if (start && fmt_i) begin
      consume_o[sel_i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= TX_IDLE;
      stage_q <= '0;
      renew_q <= 1'b0;
      data_o  <= '0;
      iq_o    <= 1'b0;
      ch_o    <= '0;
    end else if (st_q == TX_SECOND) begin
      data_o <= stage_q;
      iq_o   <= 1'b0;
      st_q   <= TX_IDLE;
    end else if (start) begin
      ch_o <= sel_i;
      iq_o <= 1'b1;
      if (fmt_i) begin
        data_o <= packed_word;
      end else begin
        data_o  <= hold_i[sel_i];
        stage_q <= hold_q[sel_i];
        renew_q <= vld_i[sel_i];
        st_q    <= TX_SECOND;
      end
    end else begin
      iq_o <= 1'b0;
    end
  end

  // R3: the cycle after an I word in split format carries Q with the flag low.
  p_q_flag_low_r3: assert property (@(posedge clk) disable iff (rst)
    (st_q == TX_SECOND) |=> !iq_o);

  // R6: the channel tag does not move between the two halves of a pair.
  p_tag_held_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == TX_SECOND) |=> $stable(ch_o));

  // R9: with no transfer starting, the bus holds and the flag is low.
  p_idle_bus_held_r9: assert property (@(posedge clk) disable iff (rst)
    (st_q == TX_IDLE && !start) |=> ($stable(data_o) && !iq_o));

endmodule

// File: rtl/iq_outport.sv
module iq_outport
  import iqp_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  localparam int CW = iqp_pkg::id_width(NCH)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NCH-1:0][DW-1:0] smp_i,
  input  logic [NCH-1:0][DW-1:0] smp_q,
  input  logic [NCH-1:0]         smp_vld,
  input  logic                   fmt_pack,
  input  logic                   cfg_alt,
  input  logic                   ack_i,
  output logic                   req_o,
  output logic [DW-1:0]          data_o,
  output logic                   iq_o,
  output logic [CW-1:0]          ch_o
);

  logic [NCH-1:0]          pend;
  logic [NCH-1:0]          consume;
  logic [NCH-1:0]          pend_nxt;
  logic [NCH-1:0][DW-1:0]  hold_i;
  logic [NCH-1:0][DW-1:0]  hold_q;
  logic [CW-1:0]           sel;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    iqp_hold #(.DW(DW)) u_hold (
      .clk      (clk),
      .rst      (rst),
      .load     (smp_vld[c]),
      .consume  (consume[c]),
      .din_i    (smp_i[c]),
      .din_q    (smp_q[c]),
      .pend_o   (pend[c]),
      .hold_i_o (hold_i[c]),
      .hold_q_o (hold_q[c])
    );
  end

  iqp_arb #(.NCH(NCH), .CW(CW)) u_arb (
    .clk    (clk),
    .rst    (rst),
    .pend_i (pend),
    .idx_o  (sel)
  );

  iqp_tx #(.NCH(NCH), .DW(DW), .CW(CW)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .req_i     (req_o),
    .ack_i     (ack_i),
    .alt_i     (cfg_alt),
    .fmt_i     (fmt_pack),
    .vld_i     (smp_vld),
    .sel_i     (sel),
    .hold_i    (hold_i),
    .hold_q    (hold_q),
    .consume_o (consume),
    .data_o    (data_o),
    .iq_o      (iq_o),
    .ch_o      (ch_o)
  );

  assign pend_nxt = smp_vld | (pend & ~consume);

  // Request is registered alongside the pending flags it summarises.
  always_ff @(posedge clk) begin
    if (rst) req_o <= 1'b0;
    else     req_o <= !cfg_alt && (|pend_nxt);
  end

  // R2: request never shows without a waiting sample.
  p_req_needs_pend_r2: assert property (@(posedge clk) disable iff (rst)
    !(|pend) |-> !req_o);

  // R10: suspension keeps the I flag down on the following cycle.
  p_alt_silences_r10: assert property (@(posedge clk) disable iff (rst)
    cfg_alt |=> !iq_o);

endmodule

// File: tb/iq_outport_tb.sv
module iq_outport_tb;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [3:0][15:0] b_i = '0;
  logic [3:0][15:0] b_q = '0;
  logic [3:0]       b_vld = '0;
  logic             fmt = 1'b0;
  logic             alt = 1'b0;
  logic             ack = 1'b0;
  logic             req_o;
  logic [15:0]      data_o;
  logic             iq_o;
  logic [1:0]       ch_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  bit    chk_en = 1'b0;
  string tag = "R1";

  always #10 clk = ~clk;

  iq_outport u_dut (
    .clk(clk), .rst(rst), .smp_i(b_i), .smp_q(b_q), .smp_vld(b_vld),
    .fmt_pack(fmt), .cfg_alt(alt), .ack_i(ack),
    .req_o(req_o), .data_o(data_o), .iq_o(iq_o), .ch_o(ch_o)
  );

  // Cycle model written from the requirements.
  logic [15:0] mi [4];
  logic [15:0] mq [4];
  logic [3:0]  m_pend;
  logic        m_busy, m_renew, m_req, m_iq;
  logic [1:0]  m_ch;
  logic [15:0] m_data, m_sq;

  always @(posedge clk) begin
    logic [3:0] clr;
    int sel;
    if (rst) begin
      m_pend = '0; m_busy = 0; m_renew = 0; m_req = 0; m_iq = 0;
      m_ch = '0; m_data = '0; m_sq = '0;
    end else begin
      clr = '0;
      if (m_busy) begin
        m_data = m_sq; m_iq = 0; m_busy = 0;
        if (!m_renew) clr[m_ch] = 1'b1;
      end else if (m_req && ack && !alt) begin
        sel = 3;
        for (int k = 3; k >= 0; k--) if (m_pend[k]) sel = k;
        m_ch = 2'(sel); m_iq = 1;
        if (fmt) begin
          m_data = {mi[sel][15:8], mq[sel][15:8]};
          clr[sel] = 1'b1;
        end else begin
          m_data = mi[sel]; m_sq = mq[sel]; m_renew = b_vld[sel]; m_busy = 1;
        end
      end else begin
        m_iq = 0;
      end
      for (int k = 0; k < 4; k++) begin
        if (b_vld[k]) begin mi[k] = b_i[k]; mq[k] = b_q[k]; m_pend[k] = 1; end
        else if (clr[k]) m_pend[k] = 0;
      end
      m_req = !alt && (|m_pend);
    end
  end

  task automatic cmp(input logic [15:0] got, input logic [15:0] exp, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %h expected %h at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      cmp(16'(req_o), 16'(m_req), "req_o");
      cmp(16'(iq_o), 16'(m_iq), "iq_o");
      cmp(16'(ch_o), 16'(m_ch), "ch_o");
      cmp(data_o, m_data, "data_o");
    end
  end

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      b_vld = '0;
    end
  endtask

  task automatic push(input int c, input logic [15:0] vi, input logic [15:0] vq);
    b_vld[c] = 1'b1; b_i[c] = vi; b_q[c] = vq;
  endtask

  // Load every subset of channels at once, then drain with ack held high.
  task automatic sweep(input logic f);
    fmt = f;
    for (int pat = 1; pat < 16; pat++) begin
      ack = 0;
      for (int c = 0; c < 4; c++)
        if (pat[c]) push(c, 16'(pat * 4096 + c * 257 + 16'h0a0), 16'(16'hf00f - pat * 291 - c * 17));
      step(1);
      ack = 1;
      step(12);
    end
    ack = 0;
    step(2);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_bad++;
        $display("FAIL watchdog got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    tag = "R1";
    cmp(16'(req_o), 16'h0, "reset req_o");
    cmp(16'(iq_o), 16'h0, "reset iq_o");
    cmp(16'(ch_o), 16'h0, "reset ch_o");
    cmp(data_o, 16'h0, "reset data_o");
    rst = 0;
    chk_en = 1;
    step(2);

    tag = "R3 R6 R8 split sweep";
    sweep(1'b0);
    tag = "R4 R5 R8 packed sweep";
    sweep(1'b1);

    tag = "R7 overwrite";
    for (int f = 0; f < 2; f++) begin
      fmt = f[0]; ack = 0;
      push(1, 16'h1111, 16'h2222); step(1);
      push(1, 16'h3333, 16'h4444); push(3, 16'h5555, 16'h6666); step(1);
      ack = 1; step(8); ack = 0; step(1);
    end

    tag = "R11 renew at start";
    for (int f = 0; f < 2; f++) begin
      fmt = f[0]; ack = 1;
      push(0, 16'h7a01, 16'h7b02); step(1);
      push(0, 16'h8c03, 16'h8d04); step(1);
      push(0, 16'h9e05, 16'h9f06); step(8);
      ack = 0; step(1);
    end

    tag = "R9 ack drop";
    fmt = 0;
    push(0, 16'h0123, 16'h4567); push(1, 16'h89ab, 16'hcdef); push(2, 16'hfeed, 16'hbeef);
    step(1);
    ack = 1; step(1);
    ack = 0; step(6);
    ack = 1; step(10);
    ack = 0; step(1);

    tag = "R10 suspend";
    for (int f = 0; f < 2; f++) begin
      fmt = f[0]; alt = 1;
      push(2, 16'hc0de, 16'hd00d); step(1);
      ack = 1; push(3, 16'hface, 16'hcafe); step(5);
      alt = 0; step(8);
      ack = 0; step(1);
    end

    tag = "R2 random mix";
    r = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      b_vld = r[3:0] & r[7:4] & r[11:8];
      for (int c = 0; c < 4; c++) begin
        b_i[c] = r[31:16] ^ 16'(c * 4369);
        b_q[c] = r[15:0] + 16'(c * 99);
      end
      ack = r[12] | r[13];
      if (r[19:15] == 0) fmt = ~fmt;
      alt = (r[24:20] == 0);
      @(negedge clk);
    end
    b_vld = '0; alt = 0; ack = 1;
    step(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule